// File: doc/BRIEF.md
# Register Hazard Interlock Detector

This combinational block decides whether the instruction in the address-computation stage of a five-stage pipeline has to wait for a register value that an older instruction has not yet written back. It takes the source register number and the need flag of the address-computation stage. It compares them with the destination register number and write flag of each of the three stages downstream: operand fetch, operate and operand store. For operand fetch and operate the write flag means "might write". For operand store it means "will write".

Every comparison is qualified by the valid bit of the consumer stage and by the valid bit of the producer stage. A bubble, a cancelled instruction or a skipped instruction therefore never causes a stall. Invalidating a producer while a stall is in progress releases the lock in the same cycle, so the waiting instruction can move on sooner. The single output is a lock request. The surrounding pipeline uses it to freeze only the fetch and address-computation stages, while the later stages keep running.

The detector holds no state. There is no data stream, so there is no valid/ready handshake and no back-pressure. All pins are plain control signals, and the output follows the inputs within the same clock period.

Top module: `reg_interlock`

## Requirements
- R1: `lock_req` is 1 when `ac_need`=1, `ac_vld`=1, `of_mightwr`=1, `of_vld`=1 and `ac_reg`==`of_reg`.
- R2: `lock_req` is 1 when `ac_need`=1, `ac_vld`=1, `op_mightwr`=1, `op_vld`=1 and `ac_reg`==`op_reg`.
- R3: `lock_req` is 1 when `ac_need`=1, `ac_vld`=1, `os_wr`=1, `os_vld`=1 and `ac_reg`==`os_reg`.
- R4: `lock_req` is the OR of the three stage tests in R1 to R3. It is 0 whenever none of those tests holds, and it stays 1 while any one of them holds.
- R5: `lock_req` is 0 whenever `ac_vld`=0 or `ac_need`=0, whatever the downstream stages present.
- R6: A producer stage with its valid bit at 0 never causes a lock. Clearing that stage's valid bit releases a lock that it alone was causing.
- R7: A producer whose write flag is 0, or whose register number differs from `ac_reg` in any bit, causes no lock. This includes numbers that differ only in the most significant bit.
- R8: `lock_req` depends only on the present input values. It responds in the same cycle and keeps no history, so the same inputs always give the same output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ac_need | input | 1 | Address-computation stage reads a register |
| ac_reg | input | REG_W | Register number that address computation reads |
| ac_vld | input | 1 | Address-computation stage holds a live instruction |
| of_mightwr | input | 1 | Operand-fetch instruction might write a register |
| of_reg | input | REG_W | Operand-fetch destination register |
| of_vld | input | 1 | Operand-fetch stage holds a live instruction |
| op_mightwr | input | 1 | Operate instruction might write a register |
| op_reg | input | REG_W | Operate destination register |
| op_vld | input | 1 | Operate stage holds a live instruction |
| os_wr | input | 1 | Operand-store instruction writes a register |
| os_reg | input | REG_W | Operand-store destination register |
| os_vld | input | 1 | Operand-store stage holds a live instruction |
| lock_req | output | 1 | Freeze request for the fetch and address-computation stages |

## Verification
The checker evaluates on every input change. It confirms that each fully qualified stage match forces a lock (R1 to R3) and that every lock can be traced to at least one qualified match (R4). It also confirms that an invalid or non-reading consumer never locks (R5), and that a pipeline whose downstream stages are all invalid never locks (R6). The bench scenarios cover the rest. These include releasing a stall by invalidating only the blocking producer, mismatches in the top bit of the register number, and applying the same inputs again after other patterns to show that no history is kept.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Producer stages that sit downstream of address computation.
  typedef enum logic [1:0] {
    PROD_OPFETCH = 2'd0,
    PROD_OPERATE = 2'd1,
    PROD_STORE   = 2'd2
  } prod_stage_e;

  localparam int unsigned NUM_PROD = 3;
endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
  parameter int unsigned REG_W = 4
) (
  input  logic             cons_need,
  input  logic             cons_vld,
  input  logic [REG_W-1:0] cons_reg,
  input  logic             prod_wr,
  input  logic             prod_vld,
  input  logic [REG_W-1:0] prod_reg,
  output logic             hit
);
  logic cons_live;
  logic prod_live;
  logic same_reg;

  always_comb begin
    cons_live = cons_need & cons_vld;
    prod_live = prod_wr & prod_vld;
    same_reg  = (cons_reg == prod_reg);
    hit       = cons_live & prod_live & same_reg;
  end
endmodule

// File: rtl/hzd_orreduce.sv
module hzd_orreduce #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] terms,
  output logic         any
);
  always_comb begin
    any = 1'b0;
    for (int i = 0; i < N; i++) any = any | terms[i];
  end
endmodule

// File: rtl/reg_interlock.sv
module reg_interlock
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W = 4
) (
  input  logic             ac_need,
  input  logic [REG_W-1:0] ac_reg,
  input  logic             ac_vld,
  input  logic             of_mightwr,
  input  logic [REG_W-1:0] of_reg,
  input  logic             of_vld,
  input  logic             op_mightwr,
  input  logic [REG_W-1:0] op_reg,
  input  logic             op_vld,
  input  logic             os_wr,
  input  logic [REG_W-1:0] os_reg,
  input  logic             os_vld,
  output logic             lock_req
);
  logic [NUM_PROD-1:0]            p_wr;
  logic [NUM_PROD-1:0]            p_vld;
  logic [NUM_PROD-1:0][REG_W-1:0] p_reg;
  logic [NUM_PROD-1:0]            p_hit;

  always_comb begin
    p_wr[PROD_OPFETCH]  = of_mightwr;
    p_vld[PROD_OPFETCH] = of_vld;
    p_reg[PROD_OPFETCH] = of_reg;
    p_wr[PROD_OPERATE]  = op_mightwr;
    p_vld[PROD_OPERATE] = op_vld;
    p_reg[PROD_OPERATE] = op_reg;
    p_wr[PROD_STORE]    = os_wr;
    p_vld[PROD_STORE]   = os_vld;
    p_reg[PROD_STORE]   = os_reg;
  end

  for (genvar g = 0; g < NUM_PROD; g++) begin : g_cmp
    hzd_match #(.REG_W(REG_W)) u_match (
      .cons_need (ac_need),
      .cons_vld  (ac_vld),
      .cons_reg  (ac_reg),
      .prod_wr   (p_wr[g]),
      .prod_vld  (p_vld[g]),
      .prod_reg  (p_reg[g]),
      .hit       (p_hit[g])
    );
  end

  hzd_orreduce #(.N(NUM_PROD)) u_or (
    .terms (p_hit),
    .any   (lock_req)
  );
endmodule

// File: rtl/reg_interlock_chk.sv
module reg_interlock_chk #(
  parameter int unsigned REG_W = 4
) (
  input logic             ac_need,
  input logic [REG_W-1:0] ac_reg,
  input logic             ac_vld,
  input logic             of_mightwr,
  input logic [REG_W-1:0] of_reg,
  input logic             of_vld,
  input logic             op_mightwr,
  input logic [REG_W-1:0] op_reg,
  input logic             op_vld,
  input logic             os_wr,
  input logic [REG_W-1:0] os_reg,
  input logic             os_vld,
  input logic             lock_req
);
  logic known;
  logic t_of, t_op, t_os;

  always_comb begin
    known = !$isunknown({ac_need, ac_reg, ac_vld, of_mightwr, of_reg, of_vld,
                         op_mightwr, op_reg, op_vld, os_wr, os_reg, os_vld, lock_req});
    t_of = ac_need && ac_vld && of_mightwr && of_vld && (ac_reg == of_reg);
    t_op = ac_need && ac_vld && op_mightwr && op_vld && (ac_reg == op_reg);
    t_os = ac_need && ac_vld && os_wr && os_vld && (ac_reg == os_reg);
    if (known) begin
      // R1
      of_match_lock_chk: assert (!t_of || lock_req);
      // R2
      op_match_lock_chk: assert (!t_op || lock_req);
      // R3
      os_match_lock_chk: assert (!t_os || lock_req);
      // R4
      lock_has_cause_chk: assert (!lock_req || t_of || t_op || t_os);
      // R5
      idle_consumer_chk: assert ((ac_need && ac_vld) || !lock_req);
      // R6
      empty_pipe_chk: assert ((of_vld || op_vld || os_vld) || !lock_req);
    end
  end
endmodule

bind reg_interlock reg_interlock_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_reg_interlock.sv
module tb_reg_interlock;
  localparam int unsigned REG_W = 4;
  localparam int unsigned NVEC  = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             ac_need, ac_vld, of_mightwr, of_vld, op_mightwr, op_vld, os_wr, os_vld;
  logic [REG_W-1:0] ac_reg, of_reg, op_reg, os_reg;
  logic             lock_req;

  int checks = 0;
  int fails  = 0;

  reg_interlock #(.REG_W(REG_W)) dut (.*);

  // Fields: exp | need,reg,vld (AC) | wr,reg,vld (OF) | (OP) | (OS)
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 1'b1,4'd3,1'b1, 1'b1,4'd3,1'b1, 1'b0,4'd0,1'b0, 1'b0,4'd0,1'b0}, // R1
    {1'b1, 1'b1,4'd7,1'b1, 1'b0,4'd7,1'b1, 1'b1,4'd7,1'b1, 1'b0,4'd0,1'b0}, // R2
    {1'b1, 1'b1,4'd9,1'b1, 1'b0,4'd0,1'b0, 1'b0,4'd0,1'b0, 1'b1,4'd9,1'b1}, // R3
    {1'b1, 1'b1,4'd5,1'b1, 1'b1,4'd5,1'b1, 1'b1,4'd5,1'b1, 1'b1,4'd5,1'b1}, // R4 all
    {1'b0, 1'b1,4'd5,1'b1, 1'b1,4'd4,1'b1, 1'b1,4'd6,1'b1, 1'b1,4'd1,1'b1}, // R4 none
    {1'b0, 1'b1,4'd2,1'b0, 1'b1,4'd2,1'b1, 1'b1,4'd2,1'b1, 1'b1,4'd2,1'b1}, // R5 ac invalid
    {1'b0, 1'b0,4'd2,1'b1, 1'b1,4'd2,1'b1, 1'b1,4'd2,1'b1, 1'b1,4'd2,1'b1}, // R5 no need
    {1'b0, 1'b1,4'd8,1'b1, 1'b1,4'd8,1'b0, 1'b0,4'd0,1'b0, 1'b0,4'd0,1'b0}, // R6 of invalid
    {1'b0, 1'b1,4'd8,1'b1, 1'b0,4'd0,1'b0, 1'b1,4'd8,1'b0, 1'b1,4'd8,1'b0}, // R6 op/os invalid
    {1'b0, 1'b1,4'd8,1'b1, 1'b0,4'd8,1'b1, 1'b0,4'd8,1'b1, 1'b0,4'd8,1'b1}, // R7 no writes
    {1'b0, 1'b1,4'd1,1'b1, 1'b1,4'd9,1'b1, 1'b1,4'd9,1'b1, 1'b1,4'd9,1'b1}, // R7 msb differs
    {1'b0, 1'b1,4'd15,1'b1,1'b1,4'd14,1'b1,1'b1,4'd7,1'b1, 1'b1,4'd13,1'b1}, // R7 near misses
    {1'b1, 1'b1,4'd15,1'b1,1'b0,4'd0,1'b0, 1'b0,4'd0,1'b0, 1'b1,4'd15,1'b1}, // R3 reg 15
    {1'b1, 1'b1,4'd0,1'b1, 1'b0,4'd0,1'b1, 1'b1,4'd0,1'b1, 1'b0,4'd0,1'b1}, // R2 reg 0
    {1'b1, 1'b1,4'd6,1'b1, 1'b1,4'd6,1'b1, 1'b0,4'd6,1'b1, 1'b0,4'd6,1'b0}, // R1 only OF
    {1'b0, 1'b0,4'd0,1'b0, 1'b0,4'd0,1'b0, 1'b0,4'd0,1'b0, 1'b0,4'd0,1'b0}  // R5 idle
  };

  task automatic apply(input logic [23:0] s);
    {ac_need, ac_reg, ac_vld, of_mightwr, of_reg, of_vld,
     op_mightwr, op_reg, op_vld, os_wr, os_reg, os_vld} = s;
  endtask

  task automatic check(input logic exp, input string req);
    @(negedge clk);
    checks++;
    if (lock_req !== exp) begin
      fails++;
      $display("FAIL %s lock_req=%b expected=%b", req, lock_req, exp);
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    apply('0);
    check(1'b0, "R5 reset idle");

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][23:0]);
      check(VEC[i][24], $sformatf("R1-4 vector %0d", i));
    end

    // R6: stall held by OP alone, then OP is invalidated -> release
    apply({1'b1,4'd10,1'b1, 1'b0,4'd0,1'b0, 1'b1,4'd10,1'b1, 1'b0,4'd0,1'b0});
    check(1'b1, "R6 stall held");
    op_vld = 1'b0;
    check(1'b0, "R6 release after invalidate");

    // R6: two producers block; removing one keeps lock, removing both frees
    apply({1'b1,4'd4,1'b1, 1'b1,4'd4,1'b1, 1'b0,4'd0,1'b0, 1'b1,4'd4,1'b1});
    check(1'b1, "R6 two blockers");
    of_vld = 1'b0;
    check(1'b1, "R4 remaining blocker");
    os_vld = 1'b0;
    check(1'b0, "R6 both invalidated");

    // R8: same inputs as vector 0 after other history give the same answer
    apply(VEC[0][23:0]);
    check(1'b1, "R8 repeat vector 0");
    apply(VEC[4][23:0]);
    check(1'b0, "R8 repeat vector 4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule